// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block is a memory-mapped event timer. A 64-bit main counter advances by one on every clock while a global enable bit is set. A parameterised number of comparator channels watch the low 32 bits of that counter. Each channel flags a match in a shared status register. It can fire once (one-shot) or, on a channel built with periodic capability, reload itself by a programmed interval and fire again.

Software reaches the block through a 32-bit register port. Reads are combinational from the address, and writes take effect on the clock edge that samples `req_i && we_i`. Two read-only words identify the counter. One is a capability word: vendor, revision, channel count and counter size. The other gives the tick period in femtoseconds, so the tick rate is 10^15 divided by that value. Each channel has a route field that selects one of `NLINES` interrupt lines. Only lines allowed by that channel's read-only route mask may be selected. In periodic mode a value-set control bit turns two successive comparator writes into "first match point, then reload interval".

Top module: `evt_timer`

## Requirements
- R1: The word at 0x000 reads {vendor[31:16], legacy-route flag bit 15 = 0, bit 14 = 0, 64-bit counter flag bit 13, channel count minus one in bits 12:8, revision in bits 7:0}. With the defaults this is 0x1D0F2202. The word at 0x004 reads the tick period in femtoseconds (default 10,000,000, i.e. 100 MHz). Both ignore writes.
- R2: Bit 0 of the global word at 0x010 enables counting. On each clock edge at which the enable is set, the counter at 0x0F0 (low) / 0x0F4 (high) grows by one. While the enable is clear the count holds, and setting the enable again resumes from the held value.
- R3: A channel matches on the clock edge at which the low 32 bits of the counter become equal to its comparator. The match sets that channel's status bit (bit n of 0x020) whether or not its interrupt is enabled.
- R4: In one-shot operation a match leaves the comparator unchanged.
- R5: A channel in periodic mode adds its reload interval to its comparator on the edge of the match.
- R6: The channel control word sits at 0x100+0x20·n and the comparator at 0x108+0x20·n. When periodic type (bit 3) and value-set (bit 6) are both set, the first comparator write loads the match point and the next write loads the reload interval without changing the comparator. Value-set then reads back 0.
- R7: On a channel without periodic capability (read-only bit 4 = 0), the periodic type and value-set bits read 0 and have no effect: every comparator write loads the comparator, and a match never reloads it.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing 0xFFFFFFFF clears every pending bit.
- R9: The channel interrupt is gated by interrupt enable (bit 2). With level type (bit 1 = 1) it follows the status bit until cleared. With edge type it is a one-cycle pulse in the cycle the status bit is set.
- R10: The route field occupies bits 13:9. A write that names a line at or above `NLINES`, or a line not set in the channel's route mask, leaves the route unchanged. The route mask reads at 0x104+0x20·n and ignores writes. The channel interrupt drives `irq_o[route]`.
- R11: Unmapped addresses read zero. Read-only fields read zero and ignore writes: bits 31:1 of the global word, and in the control word bit 0, bit 5 (64-bit comparator capability), bit 7, bit 14 (message delivery enable), bit 15 (message capability) and bits 31:16.
- R12: After reset the enable, the counter, status, routes, intervals and all control bits are zero, and every comparator reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when set with req_i |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | NLINES | Interrupt lines, driven by the routed channels |

## Verification
An error in the count or its enable shows at the counter read on the very next edge. It also shifts every match by the same number of cycles, so status and interrupt lines rise one or more cycles early or late. A wrong comparator reload or value-set phase shows at the comparator readback right after the match or the second write, and the next periodic match then lands on a different cycle. Routing and gating faults appear on `irq_o` in the match cycle, or for edge type one cycle after it. Status clear faults show at the status read on the cycle after the write.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int RW = 5;

  localparam logic [AW-1:0] OFF_CAP    = 12'h000;
  localparam logic [AW-1:0] OFF_PERIOD = 12'h004;
  localparam logic [AW-1:0] OFF_GCFG   = 12'h010;
  localparam logic [AW-1:0] OFF_STAT   = 12'h020;
  localparam logic [AW-1:0] OFF_CNT_LO = 12'h0F0;
  localparam logic [AW-1:0] OFF_CNT_HI = 12'h0F4;
  localparam logic [AW-1:0] CH_BASE    = 12'h100;
  localparam logic [AW-1:0] CH_STRIDE  = 12'h020;
  localparam logic [AW-1:0] CH_CFG     = 12'h000;
  localparam logic [AW-1:0] CH_RCAP    = 12'h004;
  localparam logic [AW-1:0] CH_CMP     = 12'h008;

  // channel control word bit positions
  localparam int B_LEVEL  = 1;
  localparam int B_IE     = 2;
  localparam int B_PER    = 3;
  localparam int B_PERCAP = 4;
  localparam int B_VSET   = 6;
  localparam int B_F32    = 8;
  localparam int B_ROUTE  = 9;

  typedef struct packed {
    logic          level;
    logic          ie;
    logic          per;
    logic          vset;
    logic          f32;
    logic [RW-1:0] route;
  } chan_cfg_t;

  function automatic logic [AW-1:0] ch_addr(int n, logic [AW-1:0] off);
    return CH_BASE + AW'(n) * CH_STRIDE + off;
  endfunction
endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q + CNT_W'(1)));
  p_hold_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import evt_timer_pkg::*;
#(
  parameter bit          PER_CAP   = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h1,
  parameter int          NLINES    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [31:0]   nxt_lo_i,
  input  logic          cfg_we_i,
  input  logic          cmp_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          stat_clr_i,
  output logic [DW-1:0] cfg_o,
  output logic [31:0]   cmp_o,
  output logic          stat_o,
  output logic          irq_o,
  output logic [RW-1:0] route_o,
  output logic          route_ok_o
);
  localparam logic [RW:0] NL = (RW+1)'(NLINES);

  chan_cfg_t   cfg_q;
  logic [31:0] cmp_q, intv_q;
  logic        phase_q, stat_q, pulse_q, match;
  logic [RW-1:0] wr_route;
  logic        wr_route_ok;

  function automatic logic route_legal(logic [RW-1:0] r);
    return ({1'b0, r} < NL) && ROUTE_CAP[r];
  endfunction

  assign wr_route    = wdata_i[B_ROUTE +: RW];
  assign wr_route_ok = route_legal(wr_route);
  assign match       = tick_i && (nxt_lo_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      phase_q <= 1'b0;
    end else if (cfg_we_i) begin
      cfg_q.level <= wdata_i[B_LEVEL];
      cfg_q.ie    <= wdata_i[B_IE];
      cfg_q.per   <= PER_CAP & wdata_i[B_PER];
      cfg_q.vset  <= PER_CAP & wdata_i[B_VSET];
      cfg_q.f32   <= wdata_i[B_F32];
      if (wr_route_ok) cfg_q.route <= wr_route;
      phase_q <= 1'b0;
    end else if (cmp_we_i && cfg_q.per && cfg_q.vset) begin
      phase_q <= !phase_q;
      if (phase_q) cfg_q.vset <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      intv_q <= '0;
    end else if (cmp_we_i) begin
      if (cfg_q.per && cfg_q.vset && phase_q) intv_q <= wdata_i;
      else                                    cmp_q  <= wdata_i;
    end else if (match && cfg_q.per) begin
      cmp_q <= cmp_q + intv_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= match;
      if (match)           stat_q <= 1'b1;
      else if (stat_clr_i) stat_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_o                   = '0;
    cfg_o[B_LEVEL]          = cfg_q.level;
    cfg_o[B_IE]             = cfg_q.ie;
    cfg_o[B_PER]            = cfg_q.per;
    cfg_o[B_PERCAP]         = PER_CAP;
    cfg_o[B_VSET]           = cfg_q.vset;
    cfg_o[B_F32]            = cfg_q.f32;
    cfg_o[B_ROUTE +: RW]    = cfg_q.route;
  end

  assign cmp_o      = cmp_q;
  assign stat_o     = stat_q;
  assign irq_o      = cfg_q.ie && (cfg_q.level ? stat_q : pulse_q);
  assign route_o    = cfg_q.route;
  assign route_ok_o = route_legal(cfg_q.route);

  p_stat_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> stat_o);
  p_oneshot_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !cfg_q.per && !cmp_we_i) |=> cmp_o == $past(cmp_o));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && cfg_q.per && !cmp_we_i) |=> cmp_o == $past(cmp_q + intv_q));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !match) |=> !stat_o);
  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[B_IE] |-> !irq_o);
endmodule

// File: rtl/evt_timer_route.sv
module evt_timer_route
  import evt_timer_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int NLINES = 8
) (
  input  logic [NCH-1:0]         irq_i,
  input  logic [NCH-1:0][RW-1:0] route_i,
  input  logic [NCH-1:0]         ok_i,
  output logic [NLINES-1:0]      line_o
);
  always_comb begin
    line_o = '0;
    for (int r = 0; r < NLINES; r++)
      for (int n = 0; n < NCH; n++)
        if (irq_i[n] && ok_i[n] && route_i[n] == RW'(r)) line_o[r] = 1'b1;
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int                    NCH       = 3,
  parameter int                    NLINES    = 8,
  parameter int                    CNT_W     = 64,
  parameter logic [31:0]           PERIOD_FS = 32'd10_000_000,
  parameter logic [15:0]           VENDOR    = 16'h1D0F,
  parameter logic [7:0]            REV       = 8'h02,
  parameter logic [NCH-1:0]        PER_CAP   = 3'b011,
  parameter logic [NCH-1:0][31:0]  ROUTE_CAP = {32'h0000_0081, 32'h0000_00F1, 32'h0000_000F}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NLINES-1:0] irq_o
);
  localparam logic [DW-1:0] CAP_WORD = {VENDOR, 1'b0, 1'b0, 1'(CNT_W > 32), 5'(NCH-1), REV};

  logic             wr, en_q;
  logic [CNT_W-1:0] cnt;
  logic [63:0]      cnt64;
  logic [NCH-1:0]   stat, ch_irq, route_ok;
  logic [NCH-1:0][RW-1:0] route;
  logic [NCH-1:0][DW-1:0] cfg_rd;
  logic [NCH-1:0][31:0]   cmp_rd;

  assign wr    = req_i && we_i;
  assign cnt64 = 64'(cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_q <= 1'b0;
    else if (wr && addr_i == OFF_GCFG)   en_q <= wdata_i[0];
  end

  evt_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .cnt_o (cnt)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    evt_timer_chan #(
      .PER_CAP  (PER_CAP[n]),
      .ROUTE_CAP(ROUTE_CAP[n]),
      .NLINES   (NLINES)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (en_q),
      .nxt_lo_i  (cnt[31:0] + 32'd1),
      .cfg_we_i  (wr && addr_i == ch_addr(n, CH_CFG)),
      .cmp_we_i  (wr && addr_i == ch_addr(n, CH_CMP)),
      .wdata_i   (wdata_i),
      .stat_clr_i(wr && addr_i == OFF_STAT && wdata_i[n]),
      .cfg_o     (cfg_rd[n]),
      .cmp_o     (cmp_rd[n]),
      .stat_o    (stat[n]),
      .irq_o     (ch_irq[n]),
      .route_o   (route[n]),
      .route_ok_o(route_ok[n])
    );
  end

  evt_timer_route #(.NCH(NCH), .NLINES(NLINES)) u_route (
    .irq_i  (ch_irq),
    .route_i(route),
    .ok_i   (route_ok),
    .line_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CAP:    rdata_o = CAP_WORD;
      OFF_PERIOD: rdata_o = PERIOD_FS;
      OFF_GCFG:   rdata_o = {31'b0, en_q};
      OFF_STAT:   rdata_o = DW'(stat);
      OFF_CNT_LO: rdata_o = cnt64[31:0];
      OFF_CNT_HI: rdata_o = cnt64[63:32];
      default: begin
        for (int n = 0; n < NCH; n++) begin
          if (addr_i == ch_addr(n, CH_CFG))  rdata_o = cfg_rd[n];
          if (addr_i == ch_addr(n, CH_RCAP)) rdata_o = ROUTE_CAP[n];
          if (addr_i == ch_addr(n, CH_CMP))  rdata_o = cmp_rd[n];
        end
      end
    endcase
  end
endmodule

// File: tb/evt_timer_test.sv
`timescale 1ns/100ps
module evt_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  irq_o;

  evt_timer uut (.*);

  always #2 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] cm = 0;
  bit en_m = 0;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // R1 id words, R12 reset values, R10 route masks/filter, R11 ro fields, R7 no-periodic channel
  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,          32'h1D0F2202, 4'd1},
    '{1'b0, 12'h004, 32'h0,          32'h00989680, 4'd1},
    '{1'b1, 12'h004, 32'hFFFFFFFF,   32'h0,        4'd1},
    '{1'b0, 12'h004, 32'h0,          32'h00989680, 4'd1},
    '{1'b0, 12'h010, 32'h0,          32'h0,        4'd12},
    '{1'b0, 12'h020, 32'h0,          32'h0,        4'd12},
    '{1'b0, 12'h0F0, 32'h0,          32'h0,        4'd12},
    '{1'b0, 12'h100, 32'h0,          32'h10,       4'd12},
    '{1'b0, 12'h120, 32'h0,          32'h10,       4'd12},
    '{1'b0, 12'h140, 32'h0,          32'h0,        4'd7},
    '{1'b0, 12'h108, 32'h0,          32'hFFFFFFFF, 4'd12},
    '{1'b0, 12'h104, 32'h0,          32'h0F,       4'd10},
    '{1'b0, 12'h124, 32'h0,          32'hF1,       4'd10},
    '{1'b0, 12'h144, 32'h0,          32'h81,       4'd10},
    '{1'b1, 12'h010, 32'hFFFFFFFE,   32'h0,        4'd11},
    '{1'b0, 12'h010, 32'h0,          32'h0,        4'd11},
    '{1'b0, 12'h0F0, 32'h0,          32'h0,        4'd2},
    '{1'b1, 12'h100, 32'h0000FFFF,   32'h0,        4'd10},
    '{1'b0, 12'h100, 32'h0,          32'h15E,      4'd10},
    '{1'b1, 12'h100, 32'h00000600,   32'h0,        4'd10},
    '{1'b0, 12'h100, 32'h0,          32'h610,      4'd10},
    '{1'b1, 12'h100, 32'h00000A00,   32'h0,        4'd10},
    '{1'b0, 12'h100, 32'h0,          32'h610,      4'd10},
    '{1'b1, 12'h140, 32'h0000004E,   32'h0,        4'd7},
    '{1'b0, 12'h140, 32'h0,          32'h6,        4'd7},
    '{1'b1, 12'h148, 32'h00001234,   32'h0,        4'd7},
    '{1'b0, 12'h148, 32'h0,          32'h1234,     4'd7},
    '{1'b1, 12'h148, 32'h00005678,   32'h0,        4'd7},
    '{1'b0, 12'h148, 32'h0,          32'h5678,     4'd7},
    '{1'b0, 12'h030, 32'h0,          32'h0,        4'd11},
    '{1'b0, 12'h10C, 32'h0,          32'h0,        4'd11},
    '{1'b0, 12'h0F8, 32'h0,          32'h0,        4'd11},
    '{1'b1, 12'h104, 32'h0,          32'h0,        4'd10},
    '{1'b0, 12'h104, 32'h0,          32'h0F,       4'd10},
    '{1'b1, 12'h100, 32'h0,          32'h0,        4'd10},
    '{1'b1, 12'h140, 32'h0,          32'h0,        4'd10}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one edge; model count per R2
  task automatic tick();
    @(negedge clk_i);
    if (en_m) cm = cm + 1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (en_m) cm = cm + 1;
    if (a == 12'h010) en_m = d[0];
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    addr_i = a;
    #0.1;
    v = rdata_o;
  endtask

  task automatic rchk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic rchk_m(string tag, logic [11:0] a, logic [31:0] m, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v & m, exp);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t, m, p, v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].exp);
        @(negedge clk_i);
      end
    end

    // R2 counting, freeze and resume
    wr(12'h010, 32'h1);
    repeat (5) tick();
    rchk("R2 count", 12'h0F0, cm[31:0]);
    rchk("R2 count hi", 12'h0F4, cm[63:32]);
    wr(12'h010, 32'h0);
    rchk("R2 stop", 12'h0F0, cm[31:0]);
    v = cm[31:0];
    repeat (4) tick();
    rchk("R2 frozen", 12'h0F0, v);
    wr(12'h010, 32'h1);
    repeat (3) tick();
    rchk("R2 resume", 12'h0F0, v + 32'd3);

    // R3 R4 R9 one-shot edge on channel 1, line 4
    wr(12'h010, 32'h0);
    wr(12'h120, 32'h00000804);
    t = cm[31:0] + 32'd20;
    wr(12'h128, t);
    wr(12'h010, 32'h1);
    while (cm[31:0] != t - 32'd1) tick();
    rchk("R3 before match", 12'h020, 32'h0);
    check("R9 no irq before", 32'(irq_o), 32'h0);
    tick();
    rchk("R3 status at match", 12'h020, 32'h2);
    check("R9 edge pulse line4", 32'(irq_o), 32'h10);
    tick();
    check("R9 pulse one cycle", 32'(irq_o), 32'h0);
    rchk("R4 comparator kept", 12'h128, t);
    repeat (10) tick();
    rchk("R3 status held", 12'h020, 32'h2);

    // R8 write-one-to-clear
    wr(12'h020, 32'h0);
    rchk("R8 zero write", 12'h020, 32'h2);
    wr(12'h020, 32'h1);
    rchk("R8 other bit", 12'h020, 32'h2);
    wr(12'h020, 32'h2);
    rchk("R8 cleared", 12'h020, 32'h0);
    wr(12'h120, 32'h0);

    // R6 value-set, R5 periodic reload, R9 level on channel 0, line 2
    wr(12'h010, 32'h0);
    wr(12'h100, 32'h0000044E);
    m = cm[31:0] + 32'd10;
    wr(12'h108, m);
    rchk("R6 vset pending", 12'h100, 32'h45E);
    wr(12'h108, 32'd7);
    rchk("R6 vset cleared", 12'h100, 32'h41E);
    rchk("R6 cmp not overwritten", 12'h108, m);
    wr(12'h010, 32'h1);
    while (cm[31:0] != m - 32'd1) tick();
    rchk_m("R3 periodic before", 12'h020, 32'h1, 32'h0);
    tick();
    rchk_m("R3 periodic match", 12'h020, 32'h1, 32'h1);
    check("R9 level line2", 32'(irq_o), 32'h04);
    rchk("R5 reload", 12'h108, m + 32'd7);
    repeat (2) tick();
    check("R9 level held", 32'(irq_o), 32'h04);
    wr(12'h020, 32'h1);
    rchk_m("R8 periodic clear", 12'h020, 32'h1, 32'h0);
    check("R9 level dropped", 32'(irq_o), 32'h0);
    while (cm[31:0] != m + 32'd7) tick();
    rchk_m("R5 second match", 12'h020, 32'h1, 32'h1);
    rchk("R5 second reload", 12'h108, m + 32'd14);
    wr(12'h100, 32'h0000040A);
    while (cm[31:0] != m + 32'd14) tick();
    wr(12'h020, 32'h0);
    rchk_m("R3 match ie off", 12'h020, 32'h1, 32'h1);
    check("R9 gated by ie", 32'(irq_o), 32'h0);
    wr(12'h020, 32'hFFFFFFFF);
    rchk("R8 all ones", 12'h020, 32'h0);

    // R7 channel without periodic capability, line 7
    wr(12'h010, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h140, 32'h00000E0E);
    rchk("R7 per bit dropped", 12'h140, 32'hE06);
    p = cm[31:0] + 32'd5;
    wr(12'h148, p);
    wr(12'h010, 32'h1);
    while (cm[31:0] != p) tick();
    rchk_m("R7 one-shot match", 12'h020, 32'h4, 32'h4);
    check("R10 line7", 32'(irq_o), 32'h80);
    rchk("R7 no reload", 12'h148, p);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule